// File: doc/BRIEF.md
# Multi-Axis Sample Ready Tracker

This block sits between a three-axis sample source and a byte-wide register read port. Each time the source pulses its strobe, the block captures one 16-bit sample per axis into holding registers and marks every axis as holding unread data. A host reads the samples one byte at a time. The block drives a single output pad. That pad carries either a ready indication or an external interrupt line, and a master enable can hold it low.

Only the axes in the enable mask count toward readiness. The ready indication rises once every enabled axis holds fresh data. It falls once every enabled axis has been read in full. A read is complete when the low byte is read and then the high byte. A mode bit selects how a sample is shown. In one mode the 12 most significant bits of the sample appear sign-extended. In the other mode the 16-bit sample appears unchanged. If a strobe arrives while an enabled axis is still unread, the new data overwrites the old and a sticky overrun flag is set.

Top module: `axrdy_top`

## Requirements
- R1: After reset, `pad_out` is 0, `overrun` is 0, every stored sample is 0 and `rd_data` reads 0.
- R2: While `cfg_pad_en` is 0, `pad_out` is 0, whatever the ready state, `cfg_int_sel` and `int_src` are.
- R3: The internal ready flag is set on the clock edge after the edge where every axis enabled in `axis_en` (bit 0 = X, 1 = Y, 2 = Z) holds fresh data. With the pad enabled and `cfg_int_sel` = 0, this means `pad_out` goes high two edges after a strobe is captured.
- R4: A disabled axis neither holds readiness back nor keeps it high.
- R5: A strobe marks all axes fresh. An axis becomes read only when a high-byte read (`rd_hi` = 1) of that axis follows a low-byte read (`rd_hi` = 0) of the same axis with no strobe in between. A high-byte read with no low-byte read before it has no effect. `rd_axis` selects 0 = X, 1 = Y, 2 = Z.
- R6: The ready flag is cleared on the edge after the edge where no enabled axis is still fresh. If a strobe and a read fall in the same cycle, the strobe wins.
- R7: With `cfg_pad_en` = 1, `cfg_int_sel` = 0 routes the ready flag to `pad_out` and `cfg_int_sel` = 1 routes `int_src`.
- R8: `rd_data` is bits 7:0 of the shown word when `rd_hi` = 0 and bits 15:8 when `rd_hi` = 1. With `cfg_left_just` = 0 the shown word is raw bits 15:4, sign-extended to 16 bits. With `cfg_left_just` = 1 it is the raw sample.
- R9: A strobe that arrives while an enabled axis is fresh sets `overrun`, which stays high until reset. The new data replaces the old and the ready flag stays high.
- R10: A change to `axis_en` is applied to the ready evaluation on the next clock edge.
- R11: Selecting an axis index of 3 or more reads 0 and changes no axis state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| axis_en | input | 3 | Per-axis enable mask |
| smp_strobe | input | 1 | New sample set valid |
| smp_data | input | 48 | Samples: X in 15:0, Y in 31:16, Z in 47:32 |
| rd_en | input | 1 | Byte read strobe |
| rd_axis | input | 2 | Axis select for the read |
| rd_hi | input | 1 | 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Selected byte |
| cfg_pad_en | input | 1 | Master enable for the pad |
| cfg_int_sel | input | 1 | Pad source: 0 = ready, 1 = interrupt |
| cfg_left_just | input | 1 | Format: 0 = 12-bit sign-extended, 1 = 16-bit raw |
| int_src | input | 1 | External interrupt line |
| pad_out | output | 1 | Ready/interrupt pad |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default three axes and 16-bit samples. With these values the out-of-range select value 3 is reachable, and the sign bit of the sample falls where the 12-bit sign extension shows it. A reference model follows every clock. It covers partial masks, high-byte reads with no low-byte read first, a mask change that releases the ready flag, and a strobe that lands on unread data.

// File: rtl/axrdy_pkg.sv
`timescale 1ns/1ps
package axrdy_pkg;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned NARR_W = 12;

  // Present a raw sample either as-is or as its top NARR_W bits sign-extended.
  function automatic logic [SMP_W-1:0] shape_sample(input logic [SMP_W-1:0] raw,
                                                    input logic left_just);
    logic [SMP_W-1:0] narrowed;
    narrowed = {{(SMP_W-NARR_W){raw[SMP_W-1]}}, raw[SMP_W-1 -: NARR_W]};
    return left_just ? raw : narrowed;
  endfunction

  // Pick the low or the high byte of a shaped word.
  function automatic logic [7:0] pick_byte(input logic [SMP_W-1:0] word, input logic hi);
    return hi ? word[15:8] : word[7:0];
  endfunction
endpackage

// File: rtl/axrdy_slot.sv
`timescale 1ns/1ps
module axrdy_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] raw_in,
  input  logic         rd_lo_hit,
  input  logic         rd_hi_hit,
  output logic [W-1:0] sample_q,
  output logic         fresh_q,
  output logic         rd_done
);
  logic lo_seen_q;

  assign rd_done = rd_hi_hit & lo_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q  <= '0;
      fresh_q   <= 1'b0;
      lo_seen_q <= 1'b0;
    end else if (load) begin
      sample_q  <= raw_in;
      fresh_q   <= 1'b1;
      lo_seen_q <= 1'b0;
    end else begin
      if (rd_lo_hit) lo_seen_q <= 1'b1;
      if (rd_done) begin
        fresh_q   <= 1'b0;
        lo_seen_q <= 1'b0;
      end
    end
  end

  // R5
  hi_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_hit && !lo_seen_q && !load) |=> fresh_q == $past(fresh_q));
  // R5
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !load) |=> !fresh_q);
  // R9
  hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sample_q));
endmodule

// File: rtl/axrdy_ready.sv
`timescale 1ns/1ps
module axrdy_ready #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] axis_en,
  input  logic [N-1:0] fresh_vec,
  input  logic         strobe,
  output logic         ready_q,
  output logic         overrun_q
);
  logic all_fresh, none_fresh, clobber;

  assign all_fresh  = (axis_en != '0) && ((fresh_vec | ~axis_en) == '1);
  assign none_fresh = (fresh_vec & axis_en) == '0;
  assign clobber    = strobe && !none_fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (all_fresh)       ready_q <= 1'b1;
      else if (none_fresh) ready_q <= 1'b0;
      if (clobber) overrun_q <= 1'b1;
    end
  end

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(all_fresh));
  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> $past(none_fresh));
  // R9
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_q) |-> $past(strobe && ((fresh_vec & axis_en) != '0)));
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |=> overrun_q);
endmodule

// File: rtl/axrdy_pad.sv
`timescale 1ns/1ps
module axrdy_pad (
  input  logic pad_en,
  input  logic int_sel,
  input  logic ready,
  input  logic int_src,
  output logic pad_out
);
  always_comb begin
    if (!pad_en)      pad_out = 1'b0;
    else if (int_sel) pad_out = int_src;
    else              pad_out = ready;
  end
endmodule

// File: rtl/axrdy_top.sv
`timescale 1ns/1ps
module axrdy_top #(
  parameter int unsigned N_AXES = 3,
  parameter int unsigned W      = axrdy_pkg::SMP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_AXES-1:0]     axis_en,
  input  logic                  smp_strobe,
  input  logic [N_AXES*W-1:0]   smp_data,
  input  logic                  rd_en,
  input  logic [((N_AXES>1)?$clog2(N_AXES):1)-1:0] rd_axis,
  input  logic                  rd_hi,
  output logic [7:0]            rd_data,
  input  logic                  cfg_pad_en,
  input  logic                  cfg_int_sel,
  input  logic                  cfg_left_just,
  input  logic                  int_src,
  output logic                  pad_out,
  output logic                  overrun
);
  localparam int unsigned SEL_W = (N_AXES > 1) ? $clog2(N_AXES) : 1;

  logic [W-1:0]      samp [N_AXES];
  logic [N_AXES-1:0] fresh_vec;
  logic [N_AXES-1:0] done_vec;
  logic              ready_q;

  for (genvar i = 0; i < N_AXES; i++) begin : g_slot
    logic lo_hit, hi_hit;
    assign lo_hit = rd_en && !rd_hi && (rd_axis == SEL_W'(i));
    assign hi_hit = rd_en &&  rd_hi && (rd_axis == SEL_W'(i));
    axrdy_slot #(.W(W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (smp_strobe),
      .raw_in    (smp_data[i*W +: W]),
      .rd_lo_hit (lo_hit),
      .rd_hi_hit (hi_hit),
      .sample_q  (samp[i]),
      .fresh_q   (fresh_vec[i]),
      .rd_done   (done_vec[i])
    );
  end

  axrdy_ready #(.N(N_AXES)) u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .axis_en   (axis_en),
    .fresh_vec (fresh_vec),
    .strobe    (smp_strobe),
    .ready_q   (ready_q),
    .overrun_q (overrun)
  );

  axrdy_pad u_pad (
    .pad_en  (cfg_pad_en),
    .int_sel (cfg_int_sel),
    .ready   (ready_q),
    .int_src (int_src),
    .pad_out (pad_out)
  );

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < N_AXES; i++) begin
      if (rd_axis == SEL_W'(i))
        rd_data = axrdy_pkg::pick_byte(axrdy_pkg::shape_sample(samp[i], cfg_left_just), rd_hi);
    end
  end

  // R2
  pad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pad_en |-> !pad_out);
  // R7
  pad_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pad_en && cfg_int_sel) |-> pad_out == int_src);
  // R5
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));
endmodule

// File: tb/axrdy_top_bench.sv
`timescale 1ns/1ps
module axrdy_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  axis_en = 3'b111;
  logic        smp_strobe = 1'b0;
  logic [47:0] smp_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_axis = 2'd0;
  logic        rd_hi = 1'b0;
  logic [7:0]  rd_data;
  logic        cfg_pad_en = 1'b0;
  logic        cfg_int_sel = 1'b0;
  logic        cfg_left_just = 1'b0;
  logic        int_src = 1'b0;
  logic        pad_out;
  logic        overrun;

  always #2 clk = ~clk;

  axrdy_top u_axrdy_top (
    .clk(clk), .rst_n(rst_n), .axis_en(axis_en), .smp_strobe(smp_strobe),
    .smp_data(smp_data), .rd_en(rd_en), .rd_axis(rd_axis), .rd_hi(rd_hi),
    .rd_data(rd_data), .cfg_pad_en(cfg_pad_en), .cfg_int_sel(cfg_int_sel),
    .cfg_left_just(cfg_left_just), .int_src(int_src), .pad_out(pad_out),
    .overrun(overrun)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference state
  int unsigned m_samp [3];
  bit m_fresh [3];
  bit m_lo [3];
  bit m_rdy, m_ovr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_samp[i] = 0; m_fresh[i] = 0; m_lo[i] = 0; end
      m_rdy = 0; m_ovr = 0;
    end else begin
      int need, got, nxt;
      need = 0; got = 0;
      for (int i = 0; i < 3; i++) if (axis_en[i]) begin need++; if (m_fresh[i]) got++; end
      if (need > 0 && got == need) nxt = 1;
      else if (got == 0) nxt = 0;
      else nxt = m_rdy;
      if (smp_strobe && got > 0) m_ovr = 1;
      if (smp_strobe) begin
        for (int i = 0; i < 3; i++) begin
          m_samp[i] = smp_data[16*i +: 16]; m_fresh[i] = 1; m_lo[i] = 0;
        end
      end else if (rd_en && rd_axis < 3) begin
        if (!rd_hi) m_lo[rd_axis] = 1;
        else if (m_lo[rd_axis]) begin m_fresh[rd_axis] = 0; m_lo[rd_axis] = 0; end
      end
      m_rdy = nxt[0];
    end
  end

  function automatic int exp_byte();
    logic [15:0] w;
    if (rd_axis >= 3) return 0;
    if (cfg_left_just) w = m_samp[rd_axis][15:0];
    else w = 16'($signed(m_samp[rd_axis][15:0]) >>> 4);
    return rd_hi ? int'(w[15:8]) : int'(w[7:0]);
  endfunction

  function automatic bit exp_pad();
    if (!cfg_pad_en) return 0;
    return cfg_int_sel ? int_src : m_rdy;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pad_out == exp_pad(), {cur_req, " pad"}, pad_out, exp_pad());
      check(overrun == m_ovr, {cur_req, " overrun"}, overrun, m_ovr);
      check(rd_data == exp_byte(), {cur_req, " rd_data"}, rd_data, exp_byte());
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic strobe(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    smp_data = {z, y, x}; smp_strobe = 1'b1; step(); smp_strobe = 1'b0;
  endtask

  task automatic read_full(input int a);
    rd_en = 1'b1; rd_axis = 2'(a); rd_hi = 1'b0; step();
    rd_hi = 1'b1; step(); rd_en = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1; step();
    // R1 reset state
    cur_req = "R1";
    check(pad_out == 0, "R1 pad", pad_out, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);
    check(rd_data == 0, "R1 rd_data", rd_data, 0);

    // R2 pad disabled: ready builds but pad stays low
    cur_req = "R2";
    strobe(16'h1234, 16'h5678, 16'h9abc); step(2);
    check(pad_out == 0, "R2 gated", pad_out, 0);
    cfg_int_sel = 1'b1; int_src = 1'b1; step();
    check(pad_out == 0, "R2 gated int", pad_out, 0);
    cfg_int_sel = 1'b0; int_src = 1'b0;
    read_full(0); read_full(1); read_full(2); step(2);

    // R3 ready rise timing
    cur_req = "R3";
    cfg_pad_en = 1'b1;
    strobe(16'h0010, 16'h0020, 16'h0030);
    check(pad_out == 0, "R3 not yet", pad_out, 0);
    step();
    check(pad_out == 1, "R3 risen", pad_out, 1);

    // R5 high byte alone does nothing; R6 stays until all read
    cur_req = "R5";
    rd_en = 1'b1; rd_axis = 2'd0; rd_hi = 1'b1; step(); rd_en = 1'b0; rd_hi = 1'b0;
    cur_req = "R6";
    read_full(1); read_full(2); step(2);
    check(pad_out == 1, "R5 X still unread", pad_out, 1);
    read_full(0); step();
    check(pad_out == 0, "R6 cleared", pad_out, 0);

    // R4 Z disabled: waits only for X and Y, Z freshness ignored
    cur_req = "R4";
    axis_en = 3'b011;
    strobe(16'h0100, 16'h0200, 16'h0300); step();
    check(pad_out == 1, "R4 ready XY", pad_out, 1);
    read_full(0); read_full(1); step();
    check(pad_out == 0, "R4 Z ignored", pad_out, 0);
    axis_en = 3'b111; read_full(2); step(2);

    // R7 interrupt routing
    cur_req = "R7";
    cfg_int_sel = 1'b1; int_src = 1'b1; step();
    check(pad_out == 1, "R7 int hi", pad_out, 1);
    int_src = 1'b0; step();
    check(pad_out == 0, "R7 int lo", pad_out, 0);
    cfg_int_sel = 1'b0;

    // R8 formatting
    cur_req = "R8";
    strobe(16'hF5A3, 16'h7FF0, 16'h8001);
    for (int a = 0; a < 3; a++) begin
      for (int lj = 0; lj < 2; lj++) begin
        cfg_left_just = lj[0]; rd_en = 1'b0; rd_axis = 2'(a);
        rd_hi = 1'b0; step(); rd_hi = 1'b1; step();
      end
    end
    rd_axis = 2'd0; rd_hi = 1'b0; cfg_left_just = 1'b0; step();
    check(rd_data == 8'h5A, "R8 X low narrow", rd_data, 8'h5A);
    rd_hi = 1'b1; step();
    check(rd_data == 8'hFF, "R8 X high narrow", rd_data, 8'hFF);
    cfg_left_just = 1'b1; step();
    check(rd_data == 8'hF5, "R8 X high raw", rd_data, 8'hF5);
    rd_hi = 1'b0; cfg_left_just = 1'b0;

    // R11 out-of-range select
    cur_req = "R11";
    rd_en = 1'b1; rd_axis = 2'd3; rd_hi = 1'b0; step(); rd_hi = 1'b1; step();
    check(rd_data == 0, "R11 zero", rd_data, 0);
    rd_en = 1'b0; rd_hi = 1'b0; step();
    check(pad_out == 1, "R11 no state change", pad_out, 1);
    read_full(0); read_full(1); read_full(2); step(2);

    // R10 mask change releases ready
    cur_req = "R10";
    strobe(16'h0aa0, 16'h0bb0, 16'h0cc0); step();
    read_full(0); read_full(1); step();
    check(pad_out == 1, "R10 Z pending", pad_out, 1);
    axis_en = 3'b011; step();
    check(pad_out == 0, "R10 mask applied", pad_out, 0);
    axis_en = 3'b111; step(2);
    check(pad_out == 0, "R10 partial stays low", pad_out, 0);
    read_full(2); step(2);

    // R9 overrun
    cur_req = "R9";
    strobe(16'h1110, 16'h2220, 16'h3330); step();
    check(overrun == 0, "R9 clean", overrun, 0);
    strobe(16'h4440, 16'h5550, 16'h6660);
    check(overrun == 1, "R9 set", overrun, 1);
    check(pad_out == 1, "R9 ready kept", pad_out, 1);
    cfg_left_just = 1'b1; rd_axis = 2'd1; rd_hi = 1'b1; step();
    check(rd_data == 8'h55, "R9 overwritten", rd_data, 8'h55);
    cfg_left_just = 1'b0; rd_hi = 1'b0;
    read_full(0); read_full(1); read_full(2); step(3);
    check(overrun == 1, "R9 sticky", overrun, 1);
    check(pad_out == 0, "R9 cleared ready", pad_out, 0);

    finish_run();
  end
endmodule